// File: doc/BRIEF.md
# Three-Phase Gate-Drive Protection Controller

This block is the digital core of a three-phase half-bridge gate driver. Each phase receives a high-side and a low-side command. The block synchronizes these commands and blocks any request that would turn on both switches of a leg. It then places a dead interval between one switch turning off and its complementary switch turning on. The results are six registered gate enables.

Three synchronous fault flags enter the block: undervoltage, overtemperature and overcurrent. Each flag passes through a consecutive-cycle filter before it counts. A confirmed fault drops every gate enable. It also turns on the pull-down of a shared active-low fault line, and that pull-down lasts at least a minimum pulse length. The same line is sampled as an input through a two-flop synchronizer, so a low driven by another phase or another chip also shuts the outputs down. Once all causes have cleared, a gate whose command is already high stays off until that command rises again.

Top module: `gdp_ctrl`

## Requirements
- R1: A high command on only one side of a phase turns on that side's gate only. With both commands of a phase low, both of its gates are off.
- R2: When both commands of a phase are high, both gates of that phase are off. The two gates of a phase are never on in the same cycle.
- R3: Between one gate of a phase turning off and the complementary gate turning on, both gates stay off for at least DEAD_CYC clock cycles.
- R4: A fault flag that is high for fewer than FILT_CYC consecutive cycles is ignored: the gates keep their state and `flt_pull_o` stays 0.
- R5: Any one of the three flags held high for FILT_CYC or more cycles turns every gate off and sets `flt_pull_o` to 1. A value of 1 on this output means the shared line is pulled low.
- R6: `flt_pull_o` stays 1 while a confirmed fault persists, and for at least PULSE_CYC cycles in total.
- R7: A low level on `flt_line_i` turns every gate off, even when no local fault exists. In that case `flt_pull_o` stays 0.
- R8: After a shutdown ends, a gate whose command stayed high throughout remains off. It turns on again only after that command goes low and then high again.
- R9: After reset all six gates are off and `flt_pull_o` is 0.
- R10: The outputs are released only when both of these hold: the minimum pull pulse has ended, and the synchronized fault line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd_i | input | 3 | High-side command per phase (asynchronous) |
| lo_cmd_i | input | 3 | Low-side command per phase (asynchronous) |
| uv_flag_i | input | 1 | Undervoltage flag (synchronous) |
| ot_flag_i | input | 1 | Overtemperature flag (synchronous) |
| oc_flag_i | input | 1 | Overcurrent flag (synchronous) |
| flt_line_i | input | 1 | Sample of the shared active-low fault line (asynchronous) |
| hi_gate_o | output | 3 | High-side gate enable per phase |
| lo_gate_o | output | 3 | Low-side gate enable per phase |
| flt_pull_o | output | 1 | 1 = pull the shared fault line low |

## Verification
The bench sends a fault pulse one cycle shorter than the filter window. A filter that counts off by one would shut down on it and raise the pull. It hands a phase from high side to low side and counts the cycles in which both gates are off. A missing or shortened dead interval shows as a gap below DEAD_CYC. After each fault type, and after an external pull-low, it keeps the command high. A design that resumed on the command level instead of a new edge would turn the gate back on at once. It also keeps the line held low after the pulse ends, which catches a release that waits only for the local pulse.

// File: rtl/gdp_pkg.sv
package gdp_pkg;

    localparam int NUM_PH  = 3;
    localparam int NUM_FLT = 3;

    typedef enum logic [1:0] {
        FLT_UV = 2'd0,
        FLT_OT = 2'd1,
        FLT_OC = 2'd2
    } flt_src_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_cmd_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_gate_t;

    function automatic int cnt_bits(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/gdp_sync.sv
module gdp_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q, stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= {W{RST_VAL}};
            stab_q <= {W{RST_VAL}};
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/gdp_deglitch.sv
module gdp_deglitch
    import gdp_pkg::*;
#(
    parameter int FILT_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_i,
    output logic conf_o
);
    localparam int CW = cnt_bits(FILT_CYC);
    localparam logic [CW-1:0] LIM  = CW'(FILT_CYC);
    localparam logic [CW-1:0] TRIP = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_q;
    logic          conf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            conf_q <= 1'b0;
        end else begin
            if (!flag_i)         run_q <= '0;
            else if (run_q < LIM) run_q <= run_q + 1'b1;
            conf_q <= flag_i && (run_q >= TRIP);
        end
    end

    assign conf_o = conf_q;

    // R4: a confirmation always follows a high flag
    a_r4_conf_follows_flag: assert property (@(posedge clk) disable iff (rst)
        conf_o |-> $past(flag_i));
endmodule

// File: rtl/gdp_phase.sv
module gdp_phase
    import gdp_pkg::*;
#(
    parameter int DEAD_CYC = 50
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      shut_i,
    input  leg_cmd_t  cmd_i,
    output leg_gate_t gate_o
);
    localparam int DW = cnt_bits(DEAD_CYC);
    localparam logic [DW-1:0] DEAD_LD = DW'(DEAD_CYC);

    leg_cmd_t      prev_q, arm_q, rise;
    leg_gate_t     gate_q;
    logic [DW-1:0] dead_q;
    logic          want_hi, want_lo;

    assign rise.hi = cmd_i.hi & ~prev_q.hi;
    assign rise.lo = cmd_i.lo & ~prev_q.lo;

    // interlock: one side only, and only once re-armed by a fresh edge
    assign want_hi = cmd_i.hi & ~cmd_i.lo & (arm_q.hi | rise.hi) & ~shut_i;
    assign want_lo = cmd_i.lo & ~cmd_i.hi & (arm_q.lo | rise.lo) & ~shut_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            arm_q  <= '0;
            gate_q <= '0;
            dead_q <= '0;
        end else begin
            prev_q <= cmd_i;
            if (shut_i) begin
                arm_q <= '0;
            end else begin
                if (rise.hi) arm_q.hi <= 1'b1;
                if (rise.lo) arm_q.lo <= 1'b1;
            end

            if (shut_i) begin
                gate_q <= '0;
                dead_q <= DEAD_LD;
            end else if (gate_q.hi && !want_hi) begin
                gate_q.hi <= 1'b0;
                dead_q    <= DEAD_LD;
            end else if (gate_q.lo && !want_lo) begin
                gate_q.lo <= 1'b0;
                dead_q    <= DEAD_LD;
            end else if (dead_q != '0) begin
                dead_q <= dead_q - 1'b1;
            end else if (want_hi && !gate_q.lo) begin
                gate_q.hi <= 1'b1;
            end else if (want_lo && !gate_q.hi) begin
                gate_q.lo <= 1'b1;
            end
        end
    end

    assign gate_o = gate_q;

    // R2: never both switches of the leg
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(gate_o.hi && gate_o.lo));
    // R3: a turn-on is never directly preceded by the complement being on
    a_r3_gap_lo: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o.lo) |-> (!$past(gate_o.hi) && !$past(gate_o.hi, 2)));
    a_r3_gap_hi: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o.hi) |-> (!$past(gate_o.lo) && !$past(gate_o.lo, 2)));
endmodule

// File: rtl/gdp_ctrl.sv
module gdp_ctrl
    import gdp_pkg::*;
#(
    parameter int DEAD_CYC  = 50,
    parameter int FILT_CYC  = 100,
    parameter int PULSE_CYC = 1250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PH-1:0] hi_cmd_i,
    input  logic [NUM_PH-1:0] lo_cmd_i,
    input  logic              uv_flag_i,
    input  logic              ot_flag_i,
    input  logic              oc_flag_i,
    input  logic              flt_line_i,
    output logic [NUM_PH-1:0] hi_gate_o,
    output logic [NUM_PH-1:0] lo_gate_o,
    output logic              flt_pull_o
);
    localparam int PW = cnt_bits(PULSE_CYC);
    localparam logic [PW-1:0] PULSE_LD = PW'(PULSE_CYC);

    logic [NUM_PH-1:0]  hi_s, lo_s;
    logic               line_s;
    logic [NUM_FLT-1:0] flag_raw, flag_conf;
    logic               fault_any, shut;
    logic [PW-1:0]      pulse_q;

    gdp_sync #(.W(2*NUM_PH), .RST_VAL(1'b0)) u_cmd_sync (
        .clk(clk), .rst(rst), .d_i({hi_cmd_i, lo_cmd_i}), .q_o({hi_s, lo_s}));

    gdp_sync #(.W(1), .RST_VAL(1'b1)) u_line_sync (
        .clk(clk), .rst(rst), .d_i(flt_line_i), .q_o(line_s));

    assign flag_raw[FLT_UV] = uv_flag_i;
    assign flag_raw[FLT_OT] = ot_flag_i;
    assign flag_raw[FLT_OC] = oc_flag_i;

    for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
        gdp_deglitch #(.FILT_CYC(FILT_CYC)) u_dg (
            .clk(clk), .rst(rst), .flag_i(flag_raw[f]), .conf_o(flag_conf[f]));
    end

    assign fault_any = |flag_conf;

    always_ff @(posedge clk) begin
        if (rst)                 pulse_q <= '0;
        else if (fault_any)      pulse_q <= PULSE_LD;
        else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
    end

    assign flt_pull_o = (pulse_q != '0);
    assign shut       = fault_any | flt_pull_o | ~line_s;

    for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
        leg_cmd_t  cmd;
        leg_gate_t gate;
        assign cmd.hi = hi_s[p];
        assign cmd.lo = lo_s[p];
        gdp_phase #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk(clk), .rst(rst), .shut_i(shut), .cmd_i(cmd), .gate_o(gate));
        assign hi_gate_o[p] = gate.hi;
        assign lo_gate_o[p] = gate.lo;
    end

    // length of the current pull-low stretch, for the R6 check
    logic [PW-1:0] pull_len_q;
    always_ff @(posedge clk) begin
        if (rst)                       pull_len_q <= '0;
        else if (!flt_pull_o)          pull_len_q <= '0;
        else if (pull_len_q < PULSE_LD) pull_len_q <= pull_len_q + 1'b1;
    end

    // R5: confirmed fault drops every gate on the next cycle
    a_r5_fault_kills_gates: assert property (@(posedge clk) disable iff (rst)
        fault_any |=> (hi_gate_o == '0 && lo_gate_o == '0));
    // R5: confirmed fault starts the pull
    a_r5_fault_pulls: assert property (@(posedge clk) disable iff (rst)
        fault_any |=> flt_pull_o);
    // R6: pull never ends before its minimum length
    a_r6_min_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(flt_pull_o) |-> (pull_len_q >= PULSE_LD));
    // R7: low shared line drops every gate on the next cycle
    a_r7_line_kills_gates: assert property (@(posedge clk) disable iff (rst)
        !line_s |=> (hi_gate_o == '0 && lo_gate_o == '0));
endmodule

// File: tb/gdp_ctrl_tb.sv
module gdp_ctrl_tb_top;
    localparam int DEAD  = 4;
    localparam int FILT  = 6;
    localparam int PULSE = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hi_cmd = '0, lo_cmd = '0;
    logic       uv = 0, ot = 0, oc = 0;
    logic       ext_pull = 0;
    logic [2:0] hi_gate, lo_gate;
    logic       flt_pull;
    wire        flt_line = ~(flt_pull | ext_pull);

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gdp_ctrl #(.DEAD_CYC(DEAD), .FILT_CYC(FILT), .PULSE_CYC(PULSE)) dut_i (
        .clk(clk), .rst(rst), .hi_cmd_i(hi_cmd), .lo_cmd_i(lo_cmd),
        .uv_flag_i(uv), .ot_flag_i(ot), .oc_flag_i(oc), .flt_line_i(flt_line),
        .hi_gate_o(hi_gate), .lo_gate_o(lo_gate), .flt_pull_o(flt_pull));

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_flag(input int idx, input logic v);
        case (idx)
            0: uv = v;
            1: ot = v;
            default: oc = v;
        endcase
    endtask

    task automatic t_reset();
        tick(1);
        check("R9 gates after reset", {hi_gate, lo_gate}, 0);
        check("R9 pull after reset", flt_pull, 0);
    endtask

    task automatic t_single_and_dead();
        int gap;
        hi_cmd[0] = 1; tick(10);
        check("R1 hi only", {hi_gate, lo_gate}, 6'b001_000);
        hi_cmd[0] = 0; lo_cmd[0] = 1;
        gap = 0;
        for (int i = 0; i < 20 && hi_gate[0]; i++) tick(1);
        for (int i = 0; i < 40 && !lo_gate[0]; i++) begin
            if (!hi_gate[0]) gap++;
            tick(1);
        end
        check("R3 dead gap at least DEAD", int'(gap >= DEAD), 1);
        check("R1 lo only", {hi_gate, lo_gate}, 6'b000_001);
        lo_cmd[0] = 0; tick(10);
        check("R1 both low", {hi_gate, lo_gate}, 0);
    endtask

    task automatic t_both_high();
        hi_cmd[1] = 1; tick(10);
        check("R1 hi phase1", hi_gate, 3'b010);
        lo_cmd[1] = 1; tick(10);
        check("R2 both high gives off", {hi_gate, lo_gate}, 0);
        hi_cmd[1] = 0; lo_cmd[1] = 0; tick(10);
    endtask

    task automatic t_glitch();
        int bad = 0;
        hi_cmd[2] = 1; tick(10);
        uv = 1;
        for (int i = 0; i < FILT - 1; i++) begin
            tick(1);
            if (!hi_gate[2] || flt_pull) bad++;
        end
        uv = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (!hi_gate[2] || flt_pull) bad++;
        end
        check("R4 short glitch ignored", bad, 0);
    endtask

    task automatic t_fault(input int idx);
        int len = 0;
        set_flag(idx, 1); tick(FILT + 3);
        check("R5 gates off on fault", {hi_gate, lo_gate}, 0);
        check("R5 pull on fault", flt_pull, 1);
        tick(5);
        check("R6 pull held during fault", flt_pull, 1);
        set_flag(idx, 0);
        for (int i = 0; i < 100 && flt_pull; i++) begin
            len++; tick(1);
        end
        check("R6 pull length after clear", int'(len >= PULSE - 1), 1);
        tick(10);
        check("R8 level-high cmd stays off", hi_gate[2], 0);
        hi_cmd[2] = 0; tick(6); hi_cmd[2] = 1; tick(10);
        check("R8 fresh edge resumes", hi_gate[2], 1);
    endtask

    task automatic t_external();
        ext_pull = 1; tick(6);
        check("R7 ext low drops gates", {hi_gate, lo_gate}, 0);
        check("R7 no own pull on ext", flt_pull, 0);
        ext_pull = 0; tick(10);
        check("R8 off after ext release", hi_gate[2], 0);
        hi_cmd[2] = 0; tick(6); hi_cmd[2] = 1; tick(10);
        check("R8 on after edge", hi_gate[2], 1);
    endtask

    task automatic t_release_needs_line();
        oc = 1; tick(FILT + 3);
        ext_pull = 1; oc = 0;
        tick(PULSE + 10);
        check("R10 pulse ended", flt_pull, 0);
        hi_cmd[2] = 0; tick(6); hi_cmd[2] = 1; tick(10);
        check("R10 held off while line low", hi_gate[2], 0);
        ext_pull = 0; tick(6);
        hi_cmd[2] = 0; tick(6); hi_cmd[2] = 1; tick(10);
        check("R10 released when line high", hi_gate[2], 1);
    endtask

    initial begin
        fork
            begin
                tick(4); rst = 0;
                t_reset();
                t_single_and_dead();
                t_both_high();
                t_glitch();
                for (int f = 0; f < 3; f++) t_fault(f);
                t_external();
                t_release_needs_line();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule